// File: doc/BRIEF.md
# LED Matrix Scan PWM Sequencer

This block sequences a time-multiplexed LED matrix. It has up to NUM_SW switch (row) enables and NUM_CS sink (column) enables. Every switch line gets one slot per frame, in ascending order. A slot opens with a blanking gap in which every output is low. The slot's switch line then goes high, and each sink runs an 8-bit pulse-width pattern whose duty comes from a byte store indexed by switch and sink. Each sink's pulse window starts a fixed number of ticks later than the sink before it, so the column edges are spread out.

A 4-bit row code sets how many switch lines take part, or selects a static mode with no scanning. A run bit blanks everything without losing stored bytes. A phase bit rotates the pulse of every second sink by half a period. Row code and phase are taken only at a frame boundary, so a frame never mixes two configurations. A single-cycle tick input paces all timing. The bytes are loaded through a simple write port.

Top module: `ledmx_scan_seq`

## Requirements
- R1: After reset every output is low while run is low, and every stored duty byte is zero, so a scan started with no writes lights no sink.
- R2: At most one switch output is high at a time. Within a frame the switch lines take their slots in ascending order starting at switch 0. A slot lasts BLANK_TICKS + 2^PWM_W + (NUM_CS-1)*STAG_TICKS ticks, and its switch line is high only after the blanking part.
- R3: Row code n, for 0 <= n <= NUM_SW-2, scans switch lines 0 to NUM_SW-1-n. The higher lines stay low, and the frame wraps to switch 0 after the last active line.
- R4: Row codes above NUM_SW-1 are not valid and scan all NUM_SW lines, exactly as code 0 does.
- R5: Row code NUM_SW-1 is the static mode. No switch output is ever high, the sinks use the bytes of switch row 0, and the one-slot pattern repeats.
- R6: The first BLANK_TICKS ticks of every slot drive every switch and sink output low.
- R7: The pulse window of sink c (numbered from 0) begins c*STAG_TICKS ticks after the blanking ends and lasts 2^PWM_W ticks.
- R8: Inside its window a sink is high for the first D ticks, where D is its duty byte. A byte of 0 keeps the sink low.
- R9: A write to address a, with 1 <= a <= NUM_SW*NUM_CS, stores the byte used by switch s and sink c (both numbered from 1), where a = (s-1)*NUM_CS + c. Writes to address 0 or above that range are ignored.
- R10: While run is low every output is low in the same cycle and the stored bytes are kept. When run rises again, scanning restarts with the blanking of switch 0.
- R11: With phase set, each sink with an odd index (numbered from 0) has its pulse rotated by half of the 2^PWM_W window, modulo the window. Even-index sinks are unchanged.
- R12: Row code and phase are captured only at a frame boundary or while run is low. A change in the middle of a frame first takes effect in the next frame.
- R13: The sequence advances one step per clock cycle in which tick is high. With tick low, every output holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base step enable |
| run_en | input | 1 | 1 = scan, 0 = blank and hold at frame start |
| row_code | input | 4 | Scan length / static mode code |
| phase_sel | input | 1 | 1 = rotate odd-index sink pulses by half a window |
| wr_en | input | 1 | Duty byte write strobe |
| wr_addr | input | 8 | Duty byte address, 1-based |
| wr_data | input | 8 | Duty byte value |
| sw_en | output | 11 | Switch (row) enables, active high |
| cs_en | output | 18 | Sink (column) enables, active high |

## Verification
The bound checker watches, on every cycle, that at most one switch line is high, that blanking and shutdown keep every output low, that no line beyond the active row count and no line in static mode is ever high, that the counters hold without a tick, and that the captured configuration only changes at a frame start. The exact pulse edges are checked only by the bench scenarios, because they depend on stored bytes and on where the design is within a frame. These edges include the sink stagger, the duty width, the half-window rotation, the address-to-LED mapping, the mid-frame reconfiguration and the restart after shutdown. The bench compares complete frames against its own reference model for several row codes.

// File: rtl/ledmx_pkg.sv
`timescale 1ns/1ps
package ledmx_pkg;
   // Number of slots in one frame for a given row code.
   // The static code counts as one slot with no switch line.
   function automatic int unsigned active_rows(input int unsigned code, input int unsigned nsw);
      if (code == nsw - 1) return 1;
      if (code <= nsw - 2) return nsw - code;
      return nsw;
   endfunction
endpackage

// File: rtl/ledmx_pwm_regfile.sv
`timescale 1ns/1ps
module ledmx_pwm_regfile #(
   parameter int NUM_SW = 11,
   parameter int NUM_CS = 18,
   parameter int PWM_W  = 8,
   parameter int ADDR_W = 8,
   parameter int SLOT_W = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [PWM_W-1:0]          wr_data,
   input  logic [SLOT_W-1:0]         rd_row,
   output logic [NUM_CS*PWM_W-1:0]   rd_duty
);
   localparam int DEPTH = NUM_SW * NUM_CS;
   localparam int IDX_W = $clog2(DEPTH);

   logic [PWM_W-1:0] mem [DEPTH];
   logic             wr_hit;
   logic [IDX_W-1:0] wr_idx;
   logic [IDX_W-1:0] row_base;

   // R9: 1-based addressing, address 0 and beyond DEPTH dropped
   assign wr_hit   = wr_en && (wr_addr != '0) && (wr_addr <= ADDR_W'(DEPTH));
   assign wr_idx   = IDX_W'(wr_addr - ADDR_W'(1));
   assign row_base = IDX_W'(rd_row) * IDX_W'(NUM_CS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_hit) begin
         mem[wr_idx] <= wr_data;
      end
   end

   for (genvar c = 0; c < NUM_CS; c++) begin : g_rd
      assign rd_duty[c*PWM_W +: PWM_W] = mem[row_base + IDX_W'(c)];
   end
endmodule

// File: rtl/ledmx_scan_timer.sv
`timescale 1ns/1ps
module ledmx_scan_timer #(
   parameter int NUM_SW   = 11,
   parameter int CODE_W   = 4,
   parameter int SLOT_LEN = 279,
   parameter int SLOT_W   = 4,
   parameter int CNT_W    = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              run_en,
   input  logic [CODE_W-1:0] cfg_code,
   input  logic              cfg_phase,
   output logic [SLOT_W-1:0] slot_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic [CODE_W-1:0] code_q,
   output logic              phase_q,
   output logic              static_q
);
   logic [SLOT_W-1:0] last_slot;
   logic              slot_end;
   logic              frame_end;

   assign static_q  = (code_q == CODE_W'(NUM_SW - 1));
   assign last_slot = SLOT_W'(ledmx_pkg::active_rows(32'(code_q), NUM_SW) - 1);
   assign slot_end  = (cnt_q == CNT_W'(SLOT_LEN - 1));
   assign frame_end = slot_end && (slot_q == last_slot);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q  <= '0;
         cnt_q   <= '0;
         code_q  <= '0;
         phase_q <= 1'b0;
      end else if (!run_en) begin
         // R10 / R12: park at frame start, keep following configuration
         slot_q  <= '0;
         cnt_q   <= '0;
         code_q  <= cfg_code;
         phase_q <= cfg_phase;
      end else if (tick) begin
         if (slot_end) begin
            cnt_q <= '0;
            if (frame_end) begin
               slot_q  <= '0;
               code_q  <= cfg_code;
               phase_q <= cfg_phase;
            end else begin
               slot_q <= slot_q + SLOT_W'(1);
            end
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/ledmx_sink_pwm.sv
`timescale 1ns/1ps
module ledmx_sink_pwm #(
   parameter int NUM_CS    = 18,
   parameter int PWM_W     = 8,
   parameter int STAG_TICKS = 1,
   parameter int CNT_W     = 9
) (
   input  logic                    act,
   input  logic [CNT_W-1:0]        act_cnt,
   input  logic                    phase,
   input  logic [NUM_CS*PWM_W-1:0] duty,
   output logic [NUM_CS-1:0]       on
);
   localparam int WIN = 2 ** PWM_W;
   localparam logic [PWM_W-1:0] HALF = PWM_W'(WIN / 2);

   for (genvar c = 0; c < NUM_CS; c++) begin : g_sink
      localparam int DLY = c * STAG_TICKS;
      logic [CNT_W-1:0] rel;
      logic             in_win;
      logic [PWM_W-1:0] lpos;
      logic [PWM_W-1:0] lpos_eff;

      assign rel    = act_cnt - CNT_W'(DLY);
      assign in_win = act && (act_cnt >= CNT_W'(DLY)) && (rel < CNT_W'(WIN));
      assign lpos   = rel[PWM_W-1:0];

      if (c % 2 == 1) begin : g_odd
         // R11: odd-index sinks rotate by half a window when phase is set
         assign lpos_eff = phase ? (lpos + HALF) : lpos;
      end else begin : g_even
         assign lpos_eff = lpos;
      end

      assign on[c] = in_win && (lpos_eff < duty[c*PWM_W +: PWM_W]);
   end
endmodule

// File: rtl/ledmx_scan_seq.sv
`timescale 1ns/1ps
module ledmx_scan_seq #(
   parameter int NUM_SW      = 11,
   parameter int NUM_CS      = 18,
   parameter int PWM_W       = 8,
   parameter int CODE_W      = 4,
   parameter int BLANK_TICKS = 6,
   parameter int STAG_TICKS  = 1,
   localparam int ADDR_W     = $clog2(NUM_SW * NUM_CS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              run_en,
   input  logic [CODE_W-1:0] row_code,
   input  logic              phase_sel,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [PWM_W-1:0]  wr_data,
   output logic [NUM_SW-1:0] sw_en,
   output logic [NUM_CS-1:0] cs_en
);
   localparam int ACT_TICKS = 2 ** PWM_W + (NUM_CS - 1) * STAG_TICKS;
   localparam int SLOT_LEN  = BLANK_TICKS + ACT_TICKS;
   localparam int CNT_W     = $clog2(SLOT_LEN);
   localparam int SLOT_W    = (NUM_SW > 1) ? $clog2(NUM_SW) : 1;

   if (NUM_SW < 2) begin : g_bad_sw
      $error("ledmx_scan_seq: NUM_SW must be at least 2");
   end
   if (2 ** CODE_W < NUM_SW) begin : g_bad_code
      $error("ledmx_scan_seq: CODE_W too narrow for static code");
   end
   if (PWM_W < 2) begin : g_bad_pwm
      $error("ledmx_scan_seq: PWM_W must be at least 2");
   end
   if (STAG_TICKS < 0 || BLANK_TICKS < 0) begin : g_bad_time
      $error("ledmx_scan_seq: tick counts must not be negative");
   end

   logic [SLOT_W-1:0]       slot_q;
   logic [CNT_W-1:0]        cnt_q;
   logic [CODE_W-1:0]       code_q;
   logic                    phase_q;
   logic                    static_q;
   logic                    blank;
   logic [CNT_W-1:0]        act_cnt;
   logic [SLOT_W-1:0]       rd_row;
   logic [NUM_CS*PWM_W-1:0] duty;
   logic [NUM_CS-1:0]       sink_on;

   ledmx_scan_timer #(
      .NUM_SW(NUM_SW), .CODE_W(CODE_W), .SLOT_LEN(SLOT_LEN),
      .SLOT_W(SLOT_W), .CNT_W(CNT_W)
   ) timer_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run_en(run_en),
      .cfg_code(row_code), .cfg_phase(phase_sel),
      .slot_q(slot_q), .cnt_q(cnt_q), .code_q(code_q),
      .phase_q(phase_q), .static_q(static_q)
   );

   // R6: blanking at the head of each slot
   if (BLANK_TICKS == 0) begin : g_no_blank
      assign blank   = 1'b0;
      assign act_cnt = cnt_q;
   end else begin : g_blank
      assign blank   = (cnt_q < CNT_W'(BLANK_TICKS));
      assign act_cnt = cnt_q - CNT_W'(BLANK_TICKS);
   end

   // R5: static mode reads row 0
   assign rd_row = static_q ? '0 : slot_q;

   ledmx_pwm_regfile #(
      .NUM_SW(NUM_SW), .NUM_CS(NUM_CS), .PWM_W(PWM_W),
      .ADDR_W(ADDR_W), .SLOT_W(SLOT_W)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_row(rd_row), .rd_duty(duty)
   );

   ledmx_sink_pwm #(
      .NUM_CS(NUM_CS), .PWM_W(PWM_W), .STAG_TICKS(STAG_TICKS), .CNT_W(CNT_W)
   ) sinks_i (
      .act(!blank), .act_cnt(act_cnt), .phase(phase_q),
      .duty(duty), .on(sink_on)
   );

   // R2 / R3 / R10: one-hot switch drive, gated by run and blanking
   for (genvar i = 0; i < NUM_SW; i++) begin : g_sw
      assign sw_en[i] = run_en && !blank && !static_q && (slot_q == SLOT_W'(i));
   end

   assign cs_en = run_en ? sink_on : '0;
endmodule

// File: rtl/ledmx_scan_chk.sv
`timescale 1ns/1ps
module ledmx_scan_chk #(
   parameter int NUM_SW      = 11,
   parameter int NUM_CS      = 18,
   parameter int CODE_W      = 4,
   parameter int CNT_W       = 9,
   parameter int SLOT_W      = 4,
   parameter int BLANK_TICKS = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run_en,
   input logic              tick,
   input logic [NUM_SW-1:0] sw_en,
   input logic [NUM_CS-1:0] cs_en,
   input logic [SLOT_W-1:0] slot,
   input logic [CNT_W-1:0]  cnt,
   input logic [CODE_W-1:0] code_q,
   input logic              static_q
);
   int unsigned rows_act;
   always_comb rows_act = ledmx_pkg::active_rows(32'(code_q), NUM_SW);

   assert_one_switch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sw_en));

   assert_rows_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_en >> rows_act) == '0);

   assert_static_dark_R5: assert property (@(posedge clk) disable iff (!rst_n)
      static_q |-> (sw_en == '0));

   assert_blank_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt < CNT_W'(BLANK_TICKS)) |-> (sw_en == '0 && cs_en == '0));

   assert_off_dark_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |-> (sw_en == '0 && cs_en == '0));

   assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (cnt == '0 && slot == '0));

   assert_cfg_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run_en) && (cnt != '0 || slot != '0)) |-> $stable(code_q));

   assert_tick_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !tick) |=> ($stable(cnt) && $stable(slot)));
endmodule

bind ledmx_scan_seq ledmx_scan_chk #(
   .NUM_SW(NUM_SW), .NUM_CS(NUM_CS), .CODE_W(CODE_W), .CNT_W(CNT_W),
   .SLOT_W(SLOT_W), .BLANK_TICKS(BLANK_TICKS)
) chk_i (
   .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick),
   .sw_en(sw_en), .cs_en(cs_en), .slot(slot_q), .cnt(cnt_q),
   .code_q(code_q), .static_q(static_q)
);

// File: tb/ledmx_scan_seq_tb_top.sv
`timescale 1ns/1ps
module ledmx_scan_seq_tb_top;
   localparam int NSW   = 11;
   localparam int NCS   = 18;
   localparam int BLANK = 6;
   localparam int STAG  = 1;
   localparam int WIN   = 256;
   localparam int SLOT  = BLANK + WIN + (NCS - 1) * STAG;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           tick = 1'b1;
   logic           run_en = 1'b0;
   logic [3:0]     row_code = 4'd0;
   logic           phase_sel = 1'b0;
   logic           wr_en = 1'b0;
   logic [7:0]     wr_addr = 8'd0;
   logic [7:0]     wr_data = 8'd0;
   logic [NSW-1:0] sw_en;
   logic [NCS-1:0] cs_en;

   always #4 clk = ~clk;

   ledmx_scan_seq dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run_en(run_en),
      .row_code(row_code), .phase_sel(phase_sel), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .sw_en(sw_en), .cs_en(cs_en)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   longint cyc = 0;
   longint base = 0;
   bit    done = 0;
   int    ref_mem [NSW*NCS];

   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      longint         at;
      logic [NSW-1:0] sw;
      logic [NCS-1:0] cs;
      string          tsw;
      string          tcs;
   } item_t;
   item_t sbq[$];

   // Reference model written from the requirements
   function automatic void model(input int code, input int ph, input int kin,
                                 output logic [NSW-1:0] sw, output logic [NCS-1:0] cs);
      int rows, fl, k, s, p, q, l, row;
      bit stat;
      stat = (code == NSW - 1);
      rows = stat ? 1 : ((code <= NSW - 2) ? NSW - code : NSW);
      fl = rows * SLOT;
      k = kin % fl;
      s = k / SLOT;
      p = k % SLOT;
      sw = '0;
      cs = '0;
      if (p >= BLANK) begin
         q = p - BLANK;
         if (!stat) sw[s] = 1'b1;
         row = stat ? 0 : s;
         for (int c = 0; c < NCS; c++) begin
            if (q >= c * STAG && q - c * STAG < WIN) begin
               l = q - c * STAG;
               if (ph != 0 && (c % 2) == 1) l = (l + WIN / 2) % WIN;
               if (l < ref_mem[row * NCS + c]) cs[c] = 1'b1;
            end
         end
      end
   endfunction

   task automatic push_span(input int code, input int ph, input int k0, input int k1,
                            input longint at0, input string tsw, input string tcs);
      for (int k = k0; k < k1; k++) begin
         item_t it;
         logic [NSW-1:0] s;
         logic [NCS-1:0] c;
         model(code, ph, k, s, c);
         it.at = at0 + longint'(k - k0);
         it.sw = s;
         it.cs = c;
         if ((k % SLOT) < BLANK) begin
            it.tsw = "R6";
            it.tcs = "R6";
         end else begin
            it.tsw = tsw;
            it.tcs = tcs;
         end
         sbq.push_back(it);
      end
   endtask

   task automatic push_dark(input longint at0, input int n, input string tag);
      for (int j = 0; j < n; j++) begin
         item_t it;
         it.at = at0 + longint'(j);
         it.sw = '0;
         it.cs = '0;
         it.tsw = tag;
         it.tcs = tag;
         sbq.push_back(it);
      end
   endtask

   task automatic drain();
      while (sbq.size() != 0) @(negedge clk);
   endtask

   // Configuration is captured while run is low, then the scan starts
   task automatic start_run(input int code, input int ph);
      @(negedge clk);
      run_en = 1'b0;
      row_code = code[3:0];
      phase_sel = ph[0];
      @(negedge clk);
      run_en = 1'b1;
      base = cyc;
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_addr = a[7:0];
      wr_data = d[7:0];
      if (a >= 1 && a <= NSW * NCS) ref_mem[a - 1] = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // Monitor: compares outputs against queued expectations
   initial begin
      item_t it;
      forever begin
         @(negedge clk);
         #2;
         while (sbq.size() != 0 && sbq[0].at <= cyc) begin
            it = sbq.pop_front();
            n_chk++;
            if (it.at != cyc) begin
               n_fail++;
               $display("FAIL %s sample missed: actual cycle %0d expected cycle %0d", it.tsw, cyc, it.at);
            end else if (sw_en !== it.sw) begin
               n_fail++;
               $display("FAIL %s sw_en at cycle %0d: actual %h expected %h", it.tsw, cyc, sw_en, it.sw);
            end else if (cs_en !== it.cs) begin
               n_fail++;
               $display("FAIL %s cs_en at cycle %0d: actual %h expected %h", it.tcs, cyc, cs_en, it.cs);
            end
         end
      end
   end

   initial begin
      repeat (400000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog (all requirements): actual hung expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NSW * NCS; i++) ref_mem[i] = 0;
      // R1: outputs low in reset and after release with run low
      repeat (2) @(negedge clk);
      push_dark(cyc, 3, "R1");
      drain();
      @(negedge clk);
      rst_n = 1'b1;
      push_dark(cyc, 5, "R1");
      drain();
      // R1: cleared storage lights no sink
      start_run(0, 0);
      push_span(0, 0, 0, 2 * SLOT, base, "R1", "R1");
      drain();

      // Load a distinct byte per LED, plus edge values (R8, R9)
      for (int s = 0; s < NSW; s++)
         for (int c = 0; c < NCS; c++)
            wr(s * NCS + c + 1, (s * 29 + c * 13 + 7) % 256);
      wr(1, 0);
      wr(2, 255);
      wr(NCS + 1, 1);
      wr(2 * NCS, 128);
      wr(0, 255);            // ignored (R9)
      wr(NSW * NCS + 1, 255); // ignored (R9)

      // R2, R7, R8, R9: full 11-line frame
      start_run(0, 0);
      push_span(0, 0, 0, NSW * SLOT, base, "R2", "R7 R8 R9");
      drain();

      // R3, R11: four lines with phase rotation, two frames
      start_run(7, 1);
      push_span(7, 1, 0, 2 * 4 * SLOT, base, "R3", "R11");
      drain();

      // R4: invalid code behaves as full scan
      start_run(13, 0);
      push_span(13, 0, 0, NSW * SLOT, base, "R4", "R4");
      drain();

      // R5: static mode, two repetitions
      start_run(10, 1);
      push_span(10, 1, 0, 2 * SLOT, base, "R5", "R5");
      drain();

      // R10: shutdown mid-frame, storage kept, restart at switch 0
      start_run(0, 0);
      push_span(0, 0, 0, 900, base, "R10", "R10");
      drain();
      @(negedge clk);
      run_en = 1'b0;
      push_dark(cyc, 40, "R10");
      drain();
      start_run(0, 0);
      push_span(0, 0, 0, NSW * SLOT, base, "R10", "R10");
      drain();

      // R12: mid-frame change applies only from the next frame
      start_run(0, 0);
      push_span(0, 0, 0, NSW * SLOT, base, "R12", "R12");
      push_span(9, 1, 0, 2 * 2 * SLOT, base + NSW * SLOT, "R12", "R12");
      while (cyc != base + 1000) @(negedge clk);
      row_code = 4'd9;
      phase_sel = 1'b1;
      drain();

      // R13: tick held low freezes the sequence
      start_run(8, 0);
      begin
         int k0;
         k0 = 400;
         push_span(8, 0, 0, k0 + 1, base, "R13", "R13");
         for (int j = 1; j <= 10; j++) begin
            item_t it;
            logic [NSW-1:0] s;
            logic [NCS-1:0] c;
            model(8, 0, k0, s, c);
            it.at = base + longint'(k0 + j);
            it.sw = s;
            it.cs = c;
            it.tsw = "R13";
            it.tcs = "R13";
            sbq.push_back(it);
         end
         push_span(8, 0, k0 + 1, k0 + 201, base + longint'(k0 + 11), "R13", "R13");
         while (cyc != base + longint'(k0)) @(negedge clk);
         tick = 1'b0;
         while (cyc != base + longint'(k0 + 10)) @(negedge clk);
         tick = 1'b1;
      end
      drain();

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule